// File: doc/BRIEF.md
# Decimal Arithmetic Adjust Unit

This unit performs the six corrections that follow binary arithmetic on packed or unpacked decimal digits held in a 16-bit accumulator. The accumulator is two bytes: a high byte and a low byte. The six operations are:

- two unpacked-digit fixes, one after an addition and one after a subtraction;
- two packed-digit fixes, one after an addition and one after a subtraction;
- a split of a binary byte into two digits after a multiply;
- a merge of two digits into one binary byte before a divide.

The last two take a radix byte. The unit reads the incoming carry and half-carry flags. It returns the new accumulator, carry, half-carry, zero, sign and parity, and a divide-fault indication.

An operation is issued by raising `in_valid` for one cycle with the operation code and operands. The result is registered. It appears with `out_valid` on the following cycle and is held until the next issue. Flag storage and instruction decode belong to the surrounding datapath.

Top module: `dadj_unit`

## Requirements
- R1: After reset, all outputs are 0. A result is presented one clock after the cycle in which `in_valid` is high, with `out_valid` high for that single cycle. While `in_valid` is low, the outputs hold their previous result.
- R2: For op code 0 (unpacked add fix), the adjust condition is: the low nibble of the low byte is above 9, or the half-carry input is 1. When it holds, the low byte becomes (low+6) AND 0x0F. The high byte becomes high+1, plus one more if the original low byte exceeded 0xF9, modulo 256. Carry and half-carry are both set.
- R3: For op codes 0 and 1, when the adjust condition is false, the low byte keeps only its low nibble. The high byte is unchanged, and carry and half-carry are both cleared.
- R4: For op code 1 (unpacked subtract fix), the adjust condition is the same as in R2. When it holds, the low byte becomes (low-6) AND 0x0F. The high byte becomes high-1, minus one more if the original low byte was below 6, modulo 256. Carry and half-carry are both set.
- R5: For op code 2 (packed add fix), the low byte is built in two steps. First, 6 is added and half-carry is set when the low nibble exceeds 9 or the half-carry input is 1. Then 0x60 is added and carry is set when the original low byte exceeds 0x99 or the carry input is 1. Any flag whose step does not apply is cleared.
- R6: For op code 3 (packed subtract fix), the low-nibble condition of R5 subtracts 6 and sets half-carry. It also sets carry if the original byte was below 6 or the carry input was 1. The original byte above 0x99, or the carry input at 1, subtracts a further 0x60 and sets carry.
- R7: Op codes 2 and 3 leave the high byte unchanged.
- R8: For op code 4 (split after multiply), with a nonzero radix, the high byte becomes low/radix and the low byte becomes low mod radix. Carry and half-carry are cleared.
- R9: For op code 4 with a radix of 0, `div_fault` is 1, the accumulator is returned unchanged, and carry and half-carry are cleared. `div_fault` is 0 for every other case.
- R10: For op code 5 (merge before divide), the low byte becomes (high*radix + low) mod 256 and the high byte becomes 0. Carry and half-carry are cleared.
- R11: For every op code, zero is 1 when the result low byte is 0, sign equals bit 7 of the result low byte, and parity is 1 when the result low byte has an even number of one bits.
- R12: Op codes 6 and 7 return the accumulator unchanged and clear carry and half-carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 3 | Operation code (see requirements) |
| acc_in | input | 16 | Accumulator, high byte in bits 15:8 |
| radix_in | input | 8 | Radix for op codes 4 and 5 |
| cf_in | input | 1 | Incoming carry |
| af_in | input | 1 | Incoming half-carry |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 16 | Adjusted accumulator |
| cf_out | output | 1 | Carry |
| af_out | output | 1 | Half-carry |
| zf_out | output | 1 | Zero |
| sf_out | output | 1 | Sign |
| pf_out | output | 1 | Even parity of result low byte |
| div_fault | output | 1 | Zero-radix fault |

## Verification
The hardest cases to reach are the cross-byte terms. These are the extra increment when the low byte is above 0xF9 with the adjust condition true, and the extra decrement when the low byte is below 6. Random operands reach them rarely, so the stimulus sends low bytes 0xFA to 0xFF and 0x00 to 0x05 with the half-carry input forced to 1. The packed subtract case with the carry input at 1 and a small byte, which sets carry from both steps, is also driven directly. A radix of 0 is injected regularly during the random phase.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  typedef enum logic [2:0] {
    OP_UNP_ADD = 3'd0,
    OP_UNP_SUB = 3'd1,
    OP_PKD_ADD = 3'd2,
    OP_PKD_SUB = 3'd3,
    OP_SPLIT   = 3'd4,
    OP_MERGE   = 3'd5
  } dadj_op_e;
endpackage

// File: rtl/dadj_unpacked.sv
module dadj_unpacked #(
  parameter int BYTE_W = 8
) (
  input  logic                  sub,
  input  logic [2*BYTE_W-1:0]   acc,
  input  logic                  af_in,
  output logic [2*BYTE_W-1:0]   acc_o,
  output logic                  adj
);
  localparam logic [BYTE_W-1:0] ALL1   = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] SIX    = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] NIBMSK = BYTE_W'(15);
  localparam logic [BYTE_W-1:0] TOPLIM = ALL1 - SIX;

  logic [BYTE_W-1:0] lo, hi, lo_n, hi_n;

  assign lo  = acc[BYTE_W-1:0];
  assign hi  = acc[2*BYTE_W-1:BYTE_W];
  assign adj = (lo[3:0] > 4'd9) || af_in;

  always_comb begin
    lo_n = lo & NIBMSK;
    hi_n = hi;
    if (adj) begin
      if (!sub) begin
        lo_n = (lo + SIX) & NIBMSK;
        hi_n = hi + BYTE_W'(1) + BYTE_W'(lo > TOPLIM);
      end else begin
        lo_n = (lo - SIX) & NIBMSK;
        hi_n = hi - BYTE_W'(1) - BYTE_W'(lo < SIX);
      end
    end
  end

  assign acc_o = {hi_n, lo_n};
endmodule

// File: rtl/dadj_packed.sv
module dadj_packed #(
  parameter int BYTE_W = 8
) (
  input  logic              sub,
  input  logic [BYTE_W-1:0] lo,
  input  logic              cf_in,
  input  logic              af_in,
  output logic [BYTE_W-1:0] lo_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam logic [BYTE_W-1:0] SIX  = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HSIX = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] HLIM = BYTE_W'(8'h99);

  logic nib_fix, hi_fix;

  assign nib_fix = (lo[3:0] > 4'd9) || af_in;
  assign hi_fix  = (lo > HLIM) || cf_in;

  always_comb begin
    lo_o = lo;
    cf_o = 1'b0;
    af_o = 1'b0;
    if (nib_fix) begin
      af_o = 1'b1;
      if (sub) begin
        lo_o = lo_o - SIX;
        if ((lo < SIX) || cf_in) cf_o = 1'b1;
      end else begin
        lo_o = lo_o + SIX;
      end
    end
    if (hi_fix) begin
      cf_o = 1'b1;
      lo_o = sub ? (lo_o - HSIX) : (lo_o + HSIX);
    end
  end
endmodule

// File: rtl/dadj_radix.sv
module dadj_radix #(
  parameter int BYTE_W = 8
) (
  input  logic                split,
  input  logic [2*BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0]   radix,
  output logic [2*BYTE_W-1:0] acc_o,
  output logic                fault
);
  localparam int PW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo, hi, quo, rem;
  logic [BYTE_W:0]   part;
  logic [PW-1:0]     prod;

  assign lo = acc[BYTE_W-1:0];
  assign hi = acc[PW-1:BYTE_W];

  always_comb begin
    rem  = '0;
    quo  = '0;
    part = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      part = {rem, lo[i]};
      if (part >= {1'b0, radix}) begin
        part   = part - {1'b0, radix};
        quo[i] = 1'b1;
      end
      rem = part[BYTE_W-1:0];
    end
  end

  assign prod  = hi * radix;
  assign fault = split && (radix == '0);

  always_comb begin
    if (split) begin
      acc_o = fault ? acc : {quo, rem};
    end else begin
      acc_o = {{BYTE_W{1'b0}}, prod[BYTE_W-1:0] + lo};
    end
  end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [2*BYTE_W-1:0] acc_in,
  input  logic [BYTE_W-1:0]   radix_in,
  input  logic                cf_in,
  input  logic                af_in,
  output logic                out_valid,
  output logic [2*BYTE_W-1:0] acc_out,
  output logic                cf_out,
  output logic                af_out,
  output logic                zf_out,
  output logic                sf_out,
  output logic                pf_out,
  output logic                div_fault
);
  import dadj_pkg::*;
  localparam int AW = 2 * BYTE_W;

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic [AW-1:0]     unp_acc, rad_acc, res_acc;
  logic              unp_adj, rad_fault;
  logic [BYTE_W-1:0] pkd_lo;
  logic              pkd_cf, pkd_af;
  logic              res_cf, res_af, res_flt;
  logic [BYTE_W-1:0] res_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  dadj_unpacked #(.BYTE_W(BYTE_W)) u_unp (
    .sub(op == OP_UNP_SUB), .acc(acc_in), .af_in(af_in),
    .acc_o(unp_acc), .adj(unp_adj)
  );

  dadj_packed #(.BYTE_W(BYTE_W)) u_pkd (
    .sub(op == OP_PKD_SUB), .lo(acc_in[BYTE_W-1:0]), .cf_in(cf_in),
    .af_in(af_in), .lo_o(pkd_lo), .cf_o(pkd_cf), .af_o(pkd_af)
  );

  dadj_radix #(.BYTE_W(BYTE_W)) u_rad (
    .split(op == OP_SPLIT), .acc(acc_in), .radix(radix_in),
    .acc_o(rad_acc), .fault(rad_fault)
  );

  always_comb begin
    res_acc = acc_in;
    res_cf  = 1'b0;
    res_af  = 1'b0;
    res_flt = 1'b0;
    case (op)
      OP_UNP_ADD, OP_UNP_SUB: begin
        res_acc = unp_acc;
        res_cf  = unp_adj;
        res_af  = unp_adj;
      end
      OP_PKD_ADD, OP_PKD_SUB: begin
        res_acc = {acc_in[AW-1:BYTE_W], pkd_lo};
        res_cf  = pkd_cf;
        res_af  = pkd_af;
      end
      OP_SPLIT, OP_MERGE: begin
        res_acc = rad_acc;
        res_flt = rad_fault;
      end
      default: ;
    endcase
  end
  assign res_lo = res_acc[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_out   <= '0;
      cf_out    <= 1'b0;
      af_out    <= 1'b0;
      zf_out    <= 1'b0;
      sf_out    <= 1'b0;
      pf_out    <= 1'b0;
      div_fault <= 1'b0;
    end else if (in_valid) begin
      acc_out   <= res_acc;
      cf_out    <= res_cf;
      af_out    <= res_af;
      zf_out    <= (res_lo == '0);
      sf_out    <= res_lo[BYTE_W-1];
      pf_out    <= ~(^res_lo);
      div_fault <= res_flt;
    end
  end
endmodule

// File: rtl/dadj_chk.sv
module dadj_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [15:0] acc_in,
  input logic        out_valid,
  input logic [15:0] acc_out,
  input logic        cf_out,
  input logic        af_out,
  input logic        zf_out,
  input logic        pf_out,
  input logic        div_fault
);
  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out));

  a_r3_nibble_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) <= 3'd1)) |-> (acc_out[7:4] == 4'd0 && cf_out == af_out));

  a_r7_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == 3'd2 || $past(op) == 3'd3)) |->
      (acc_out[15:8] == $past(acc_in[15:8])));

  a_r9_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && div_fault) |-> (acc_out == $past(acc_in) && $past(op) == 3'd4));

  a_r10_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == 3'd5) |-> (acc_out[15:8] == 8'd0 && !cf_out && !af_out));

  a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pf_out == ($countones(acc_out[7:0]) % 2 == 0) &&
                   zf_out == (acc_out[7:0] == 8'd0)));
endmodule

bind dadj_unit dadj_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_in(acc_in),
  .out_valid(out_valid), .acc_out(acc_out), .cf_out(cf_out), .af_out(af_out),
  .zf_out(zf_out), .pf_out(pf_out), .div_fault(div_fault)
);

// File: tb/tb_dadj_unit.sv
module tb_dadj_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] acc_in = '0;
  logic [7:0]  radix_in = '0;
  logic        cf_in = 1'b0, af_in = 1'b0;
  logic        out_valid;
  logic [15:0] acc_out;
  logic        cf_out, af_out, zf_out, sf_out, pf_out, div_fault;

  int total = 0, bad = 0;
  bit checking = 1'b0;

  // model state: {valid, acc, cf, af, zf, sf, pf, fault}
  logic [22:0] m_state = '0;
  int m_lastop = 0;

  always #2 clk = ~clk;

  dadj_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_in(acc_in),
    .radix_in(radix_in), .cf_in(cf_in), .af_in(af_in), .out_valid(out_valid),
    .acc_out(acc_out), .cf_out(cf_out), .af_out(af_out), .zf_out(zf_out),
    .sf_out(sf_out), .pf_out(pf_out), .div_fault(div_fault)
  );

  function automatic logic [21:0] ref_fn(int o, int a, int rdx, int c, int h);
    int lo = a & 255, hi = (a >> 8) & 255, nlo = lo, nhi = hi;
    int fc = 0, fa = 0, ff = 0, ones = 0;
    bit cond = ((lo & 15) > 9) || (h != 0);
    case (o)
      0: if (cond) begin nlo = (lo + 6) & 15; nhi = (hi + 1 + (lo > 249 ? 1 : 0)) & 255; fc = 1; fa = 1; end
         else nlo = lo & 15;
      1: if (cond) begin nlo = (lo - 6) & 15; nhi = (hi - 1 - (lo < 6 ? 1 : 0)) & 255; fc = 1; fa = 1; end
         else nlo = lo & 15;
      2: begin
        if (cond) begin nlo = (nlo + 6) & 255; fa = 1; end
        if (lo > 153 || c != 0) begin nlo = (nlo + 96) & 255; fc = 1; end
      end
      3: begin
        if (cond) begin fa = 1; if (lo < 6 || c != 0) fc = 1; nlo = (nlo - 6) & 255; end
        if (lo > 153 || c != 0) begin nlo = (nlo - 96) & 255; fc = 1; end
      end
      4: if (rdx == 0) ff = 1;
         else begin nhi = lo / rdx; nlo = lo % rdx; end
      5: begin nlo = (hi * rdx + lo) & 255; nhi = 0; end
      default: ;
    endcase
    for (int b = 0; b < 8; b++) ones += (nlo >> b) & 1;
    return {nhi[7:0], nlo[7:0], fc[0], fa[0], (nlo == 0), nlo[7], (ones % 2 == 0), ff[0]};
  endfunction

  function automatic string tag(int o);
    case (o)
      0: return "R2 R3 R11";
      1: return "R4 R3 R11";
      2: return "R5 R7 R11";
      3: return "R6 R7 R11";
      4: return "R8 R9 R11";
      5: return "R10 R11";
      default: return "R12 R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_state[22] <= in_valid;
      if (in_valid) begin
        m_state[21:0] <= ref_fn(int'(op), int'(acc_in), int'(radix_in), int'(cf_in), int'(af_in));
        m_lastop <= int'(op);
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [22:0] got;
      got = {out_valid, acc_out, cf_out, af_out, zf_out, sf_out, pf_out, div_fault};
      total++;
      if (got !== m_state) begin
        bad++;
        $display("FAIL %s R1: got=%h exp=%h", m_state[22] ? tag(m_lastop) : "R1", got, m_state);
      end
    end
  end

  task automatic issue(int o, int a, int rdx, int c, int h);
    @(negedge clk);
    op = 3'(o); acc_in = 16'(a); radix_in = 8'(rdx); cf_in = c[0]; af_in = h[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #40000000;
    bad++; total++;
    $display("FAIL watchdog R1: got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    total++;
    if ({out_valid, acc_out, cf_out, af_out, zf_out, sf_out, pf_out, div_fault} !== '0) begin
      bad++;
      $display("FAIL R1: got=%h exp=0", acc_out);
    end
    checking = 1'b1;
    // R2 cross-byte carry and R4 cross-byte borrow
    for (int v = 250; v < 256; v++) issue(0, 16'h1200 | v, 0, 0, 1);
    for (int v = 0; v < 6; v++) issue(1, 16'h1200 | v, 0, 0, 1);
    issue(0, 16'hFFFF, 0, 0, 1);
    issue(1, 16'h0000, 0, 0, 1);
    issue(0, 16'h3405, 0, 1, 0);   // R3 no adjust
    issue(1, 16'h34A9, 0, 0, 0);   // R3 no adjust
    issue(2, 16'h559A, 0, 0, 0);   // R5
    issue(2, 16'h5500, 0, 1, 1);   // R5
    issue(3, 16'h5503, 0, 1, 1);   // R6 both carries
    issue(3, 16'h55A0, 0, 0, 0);   // R6
    issue(4, 16'h77FF, 10, 0, 0);  // R8
    issue(4, 16'h7763, 0, 1, 1);   // R9 zero radix
    issue(5, 16'h0907, 10, 1, 1);  // R10
    issue(5, 16'hFFFF, 255, 0, 0); // R10 truncation
    issue(6, 16'hABCD, 3, 1, 1);   // R12
    issue(7, 16'h0000, 3, 1, 1);   // R12
    repeat (5) @(negedge clk);     // R1 hold
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      op = 3'($urandom_range(0, 7));
      acc_in = 16'($urandom);
      radix_in = ($urandom_range(0, 7) == 0) ? 8'd0 : 8'($urandom);
      cf_in = 1'($urandom);
      af_in = 1'($urandom);
      in_valid = 1'($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checking = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule